// File: doc/BRIEF.md
# Threshold-Paced Transmit Audio FIFO

This block is a 64-word, 32-bit write buffer. It sits between a host or DMA engine and a transmitter that drives several audio serializers. It paces the host by free space. Whenever the buffer is enabled and has room for a programmed burst (the event count), it raises a request. It then accepts exactly that many words over a valid/ready handshake and drops the request. After that it looks again at its free space, so it keeps itself as full as it can.

On the transmitter side, a one-cycle data request is gated by occupancy. The block sends a programmed group of words (the transfer count) back to back, in arrival order. It does this only once that many words are stored. Until then the request stays pending.

Both counts are tied to the number of active transmit serializers. They can be changed only while the buffer is disabled. A sticky error flag reports an attempt to break either rule. Disabling the buffer empties it and cancels every pending request.

Top module: `txaud_fifo`

## Requirements
- R1: After a synchronous reset, `host_req`, `tx_valid`, `fifo_on` and `cfg_err` are low and `level` is 0.
- R2: While enabled, `host_req` rises when free space (64 minus `level`) is at least the event count. It is high at the second rising edge after the enabling write. It stays low while free space is below the event count.
- R3: A raised request holds `host_req` and `host_ready` high until exactly event-count words have been accepted. Then it falls, and it is raised again when room remains.
- R4: Each `tx_req` pulse releases exactly transfer-count words on `tx_valid`/`tx_data`, in the order the host wrote them.
- R5: If fewer than transfer-count words are stored, a `tx_req` stays pending and no word is released. Once enough words are present, it is served.
- R6: A write to a count register while enabled changes nothing. Address 0 is the event count and address 1 is the transfer count. The write sets `cfg_err`, which stays set until reset.
- R7: A write to address 2 with bit 0 set enables the buffer only if all of these hold: `ser_cnt` is 1 to 16, the transfer count equals `ser_cnt`, and the event count is nonzero, at most 64 and a multiple of `ser_cnt`. Otherwise the buffer stays disabled and `cfg_err` is set. Writing bit 0 clear disables the buffer.
- R8: Disabling flushes the buffer. One cycle later `level` is 0 and `host_req` is low. A pending transmit request is dropped, and flushed words are never delivered.
- R9: `level` reports the number of words stored: words accepted minus words released.
- R10: At most 64 words are ever held. The host is never granted a write into a full buffer.
- R11: A host word accepted in the same cycle as a word released leaves `level` unchanged. Neither word is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_cnt | input | 5 | Number of active transmit serializers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 event count, 1 transfer count, 2 control |
| cfg_wdata | input | 7 | Configuration write data (control: bit 0 enable) |
| host_req | output | 1 | Request for a burst of event-count words |
| host_valid | input | 1 | Host word valid |
| host_data | input | 32 | Host word |
| host_ready | output | 1 | Host word accepted when high with `host_valid` |
| tx_req | input | 1 | One-cycle data request from the transmitter |
| tx_valid | output | 1 | Released word valid |
| tx_data | output | 32 | Released word |
| level | output | 7 | Words currently stored |
| fifo_on | output | 1 | Buffer enabled |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A host refill burst and a group released to the transmitter can share clock cycles. The bench provokes this by draining the buffer below the refill threshold and waiting for the refill request. It then raises a transmitter request, so the release overlaps the host burst. The overlap is judged on the final `level`, which must equal the count arithmetic alone, and on the scoreboard, which must see every word once and in host order.

// File: rtl/txaud_pkg.sv
`timescale 1ns/1ps
package txaud_pkg;
  typedef enum logic [1:0] {
    REG_EVT  = 2'd0,
    REG_XFR  = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/txaud_ram.sv
`timescale 1ns/1ps
module txaud_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/txaud_cfg.sv
`timescale 1ns/1ps
module txaud_cfg
  import txaud_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_SER = 16,
  parameter int CNT_W   = 7,
  parameter int SER_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [SER_W-1:0] ser_cnt,
  output logic [CNT_W-1:0] evt_cnt,
  output logic [CNT_W-1:0] xfr_cnt,
  output logic             fifo_on,
  output logic             cfg_err
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] MAXS_C  = CNT_W'(MAX_SER);

  logic [CNT_W-1:0] ser_ext, ser_div;
  logic             legal;
  cfg_sel_e         sel;

  always_comb begin
    sel     = cfg_sel_e'(cfg_addr);
    ser_ext = CNT_W'(ser_cnt);
    ser_div = (ser_ext == '0) ? CNT_W'(1) : ser_ext;
    legal   = (ser_ext != '0) && (ser_ext <= MAXS_C) && (xfr_cnt == ser_ext) &&
              (evt_cnt != '0) && (evt_cnt <= DEPTH_C) &&
              ((evt_cnt % ser_div) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_cnt <= '0;
      xfr_cnt <= '0;
      fifo_on <= 1'b0;
      cfg_err <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        REG_EVT: begin
          if (fifo_on) cfg_err <= 1'b1;
          else         evt_cnt <= cfg_wdata;
        end
        REG_XFR: begin
          if (fifo_on) cfg_err <= 1'b1;
          else         xfr_cnt <= cfg_wdata;
        end
        REG_CTL: begin
          if (cfg_wdata[0]) begin
            if (legal) fifo_on <= 1'b1;
            else       cfg_err <= 1'b1;
          end else begin
            fifo_on <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R6
  cnt_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && cfg_we && (cfg_addr == 2'd0 || cfg_addr == 2'd1))
      |=> (cfg_err && $stable(evt_cnt) && $stable(xfr_cnt)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R7
  on_counts_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_on |-> (evt_cnt != '0 && xfr_cnt != '0 && evt_cnt <= DEPTH_C));
endmodule

// File: rtl/txaud_host_pacer.sv
`timescale 1ns/1ps
module txaud_host_pacer #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] evt_cnt,
  input  logic             host_valid,
  output logic             host_req,
  output logic             push
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_words;
  logic [CNT_W-1:0] beats;

  assign free_words = DEPTH_C - level;
  assign push       = host_req & host_valid;

  always_ff @(posedge clk) begin
    if (rst || !fifo_on) begin
      host_req <= 1'b0;
      beats    <= '0;
    end else if (!host_req) begin
      if (evt_cnt != '0 && free_words >= evt_cnt) begin
        host_req <= 1'b1;
        beats    <= '0;
      end
    end else if (host_valid) begin
      beats <= beats + 1'b1;
      if (beats == evt_cnt - 1'b1) host_req <= 1'b0;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst || !fifo_on)
    (host_req && !host_valid) |=> host_req);

  // R2
  req_room_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_req) |-> (free_words >= evt_cnt));
endmodule

// File: rtl/txaud_release.sv
`timescale 1ns/1ps
module txaud_release #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] xfr_cnt,
  input  logic             tx_req,
  output logic             pop
);
  logic             pending, active, start;
  logic [CNT_W-1:0] remain;

  assign start = pending && !active && xfr_cnt != '0 && level >= xfr_cnt;
  assign pop   = active;

  always_ff @(posedge clk) begin
    if (rst || !fifo_on) begin
      pending <= 1'b0;
      active  <= 1'b0;
      remain  <= '0;
    end else begin
      pending <= (pending && !start) || tx_req;
      if (start) begin
        active <= 1'b1;
        remain <= xfr_cnt;
      end else if (active) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) active <= 1'b0;
      end
    end
  end

  // R5
  gate_open_chk: assert property (@(posedge clk) disable iff (rst || !fifo_on)
    $rose(active) |-> ($past(level) >= xfr_cnt));

  // R4
  group_len_chk: assert property (@(posedge clk) disable iff (rst || !fifo_on)
    (active && remain > CNT_W'(1)) |=> active);
endmodule

// File: rtl/txaud_fifo.sv
`timescale 1ns/1ps
module txaud_fifo #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_SER = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int SER_W  = $clog2(MAX_SER) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SER_W-1:0]  ser_cnt,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              host_req,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_ready,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [CNT_W-1:0]  level,
  output logic              fifo_on,
  output logic              cfg_err
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0]  evt_cnt, xfr_cnt;
  logic              push, pop;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  txaud_cfg #(.DEPTH(DEPTH), .MAX_SER(MAX_SER), .CNT_W(CNT_W), .SER_W(SER_W)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ser_cnt(ser_cnt), .evt_cnt(evt_cnt), .xfr_cnt(xfr_cnt),
    .fifo_on(fifo_on), .cfg_err(cfg_err)
  );

  txaud_host_pacer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) pacer_i (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .level(level), .evt_cnt(evt_cnt),
    .host_valid(host_valid), .host_req(host_req), .push(push)
  );

  txaud_release #(.CNT_W(CNT_W)) rel_i (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .level(level), .xfr_cnt(xfr_cnt),
    .tx_req(tx_req), .pop(pop)
  );

  txaud_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .wr_en(push), .wr_addr(wr_ptr), .wr_data(host_data),
    .rd_en(pop), .rd_addr(rd_ptr), .rd_data(tx_data)
  );

  assign host_ready = host_req;

  always_ff @(posedge clk) begin
    if (rst || !fifo_on) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_valid <= 1'b0;
    else     tx_valid <= pop;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (level < DEPTH_C || pop));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |=> (level == '0 && !host_req));

  // R10
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_C);
endmodule

// File: tb/txaud_fifo_tb.sv
`timescale 1ns/1ps
module txaud_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ser_cnt = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [6:0]  cfg_wdata = '0;
  logic        host_req, host_ready, tx_valid, fifo_on, cfg_err;
  logic        host_valid = 1'b0;
  logic [31:0] host_data = '0;
  logic        tx_req = 1'b0;
  logic [31:0] tx_data;
  logic [6:0]  level;

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0;
  int beats = 0, evt_exp = 0;
  bit auto_on = 0, burst_chk = 0, prev_ready = 0;
  logic [31:0] seq = 32'hA000_0000;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  txaud_fifo dut_i (
    .clk(clk), .rst(rst), .ser_cnt(ser_cnt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .host_req(host_req), .host_valid(host_valid),
    .host_data(host_data), .host_ready(host_ready), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_data(tx_data), .level(level), .fifo_on(fifo_on),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // host driver: answers requests, pushes each driven word into the scoreboard
  always @(negedge clk) begin
    if (!rst && auto_on && host_ready) begin
      host_valid = 1'b1;
      host_data  = seq;
      exp_q.push_back(seq);
      seq++;
      beats++;
    end else begin
      host_valid = 1'b0;
    end
    if (prev_ready && !host_ready) begin
      // R3: burst length equals the event count
      if (burst_chk && beats != 0) chk(beats == evt_exp, "R3 burst length", beats, evt_exp);
      beats = 0;
    end
    prev_ready = host_ready;
  end

  // monitor: compares released words with the scoreboard, R4 order
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      rx_cnt++;
      if (exp_q.size() == 0) chk(0, "R4 word with empty scoreboard", tx_data, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e, "R4 data order", tx_data, e);
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tx_pulse();
    @(negedge clk);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic do_reset();
    auto_on = 0; burst_chk = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk(host_req == 0, "R1 host_req", host_req, 0);
    chk(level == 0, "R1 level", level, 0);
    chk(fifo_on == 0, "R1 fifo_on", fifo_on, 0);
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);

    // R7: event count not a multiple of serializers
    ser_cnt = 5'd4;
    cfg_wr(2'd0, 7'd6);
    cfg_wr(2'd1, 7'd4);
    cfg_wr(2'd2, 7'd1);
    chk(fifo_on == 0, "R7 illegal enable", fifo_on, 0);
    chk(cfg_err == 1, "R7 illegal flag", cfg_err, 1);
    repeat (2) @(negedge clk);
    chk(host_req == 0, "R7 no request when disabled", host_req, 0);

    // legal setup
    do_reset();
    ser_cnt = 5'd4;
    cfg_wr(2'd0, 7'd8);
    cfg_wr(2'd1, 7'd4);
    cfg_wr(2'd2, 7'd1);
    chk(fifo_on == 1, "R7 legal enable", fifo_on, 1);
    chk(cfg_err == 0, "R7 legal no flag", cfg_err, 0);
    @(negedge clk);
    chk(host_req == 1, "R2 request raised", host_req, 1);
    chk(level == 0, "R9 level empty", level, 0);
    evt_exp = 8; burst_chk = 1; auto_on = 1;
    repeat (150) @(negedge clk);
    chk(level == 64, "R10 full level", level, 64);
    chk(host_req == 0, "R2 no request when full", host_req, 0);

    // R6: event count write while enabled is ignored
    cfg_wr(2'd0, 7'd4);
    chk(cfg_err == 1, "R6 flag set", cfg_err, 1);
    tx_pulse();
    repeat (30) @(negedge clk);
    chk(level == 60, "R6 evt ignored level", level, 60);
    chk(host_req == 0, "R6 evt ignored no request", host_req, 0);
    chk(rx_cnt == 4, "R4 group size", rx_cnt, 4);

    // R6: transfer count write while enabled is ignored
    cfg_wr(2'd1, 7'd8);
    tx_pulse();
    repeat (40) @(negedge clk);
    chk(rx_cnt == 8, "R6 xfr ignored group size", rx_cnt, 8);
    chk(level == 64, "R3 refilled after room", level, 64);
    chk(cfg_err == 1, "R6 flag sticky", cfg_err, 1);

    // R11: release overlaps a host burst
    tx_pulse();
    repeat (15) @(negedge clk);
    tx_pulse();
    for (int i = 0; i < 60 && !host_req; i++) @(negedge clk);
    tx_pulse();
    repeat (40) @(negedge clk);
    chk(level == 60, "R11 level after overlap", level, 60);
    chk(rx_cnt == 20, "R11 words released", rx_cnt, 20);
    chk(exp_q.size() == 60, "R9 level matches scoreboard", exp_q.size(), 60);

    // R8: disable flushes
    auto_on = 0; burst_chk = 0;
    repeat (5) @(negedge clk);
    cfg_wr(2'd2, 7'd0);
    exp_q.delete();
    chk(fifo_on == 0, "R8 disabled", fifo_on, 0);
    @(negedge clk);
    chk(level == 0, "R8 level flushed", level, 0);
    chk(host_req == 0, "R8 request dropped", host_req, 0);

    // R5: pending release waits for words
    ser_cnt = 5'd2;
    cfg_wr(2'd0, 7'd2);
    cfg_wr(2'd1, 7'd2);
    cfg_wr(2'd2, 7'd1);
    chk(fifo_on == 1, "R7 re-enable", fifo_on, 1);
    tx_pulse();
    repeat (10) @(negedge clk);
    chk(rx_cnt == 20, "R5 held while empty", rx_cnt, 20);
    chk(level == 0, "R5 level empty", level, 0);
    evt_exp = 2; burst_chk = 1; auto_on = 1;
    repeat (15) @(negedge clk);
    chk(rx_cnt == 22, "R5 released once filled", rx_cnt, 22);
    repeat (100) @(negedge clk);
    chk(level == 64, "R10 refill to capacity", level, 64);
    chk(exp_q.size() == 64, "R8 only new data held", exp_q.size(), 64);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule